// File: doc/BRIEF.md
# Multi-format serial audio receiver

This block turns a serial audio stream into parallel samples. The stream is two's-complement and arrives MSB first. A bit clock, a word clock and up to three data pins carry it, and all of them are already synchronised to the system clock. The block looks for edges on the bit clock and counts bit positions from the framing edge of the word clock. It then places each bit into the correct channel and bit position.

There are two families of framing. The first is the stereo framings: I2S, left-justified, right-justified and DSP frame-sync. In these, each data pin carries one stereo pair. The second is the packed framings, where all six channels travel on pin 0 inside one sample interval. A finished frame is moved into six 24-bit output words in a single cycle, and a one-cycle strobe marks the transfer.

Samples are left-aligned in the 24-bit word, and bits below the word length read as zero. `mode` and `wlen` are meant to stay static while traffic flows. Changing either one drops framing lock, and the receiver waits for a fresh framing edge before it accepts data again.

Top module: `serial_audio_rx`

## Requirements
- R1: While reset is asserted and right after it, `pcm` is all zeros and `frame_valid` is low.
- R2: With mode 000 (I2S), the word clock is low during the left word. The MSB is sampled on the second bit-clock rising edge after the word clock changes level.
- R3: With mode 011 (left-justified), the word clock is high during the left word. The MSB is sampled on the first bit-clock rising edge after the word clock changes level.
- R4: With mode 001 (right-justified), the word clock is high during the left word. The LSB is sampled on the 32nd rising edge of the half frame, so the MSB comes 32 minus the word length edges after the change.
- R5: With mode 010 (DSP), data is sampled on falling edges of the bit clock. A rising word clock starts a word, and its MSB follows one bit later. Words alternate left, right, left, and so on, starting with left after reset.
- R6: With mode 100 (256-clock packed), pin 0 carries eight 32-bit slots, and a falling word clock marks slot 0. Slots 0, 1 and 2 hold left channels 0, 1 and 2. Slots 4, 5 and 6 hold right channels 0, 1 and 2. Slots 3 and 7 are unused. Each word starts one bit into its slot.
- R7: With mode 101 (128-clock packed), a rising word clock starts the frame. Bits 0 to 59 form three 20-bit left slots and bits 64 to 123 form three 20-bit right slots, with each word starting at its slot's first bit. The word length is capped at 20 bits.
- R8: `wlen` sets the number of captured bits: 00 gives 24, 01 gives 20, 10 gives 16, and 11 gives 24. Bits past the word length are ignored, and the low bits of the left-aligned sample are zero.
- R9: In the `pcm` output, channel c sits at bits [24c+23:24c]. Left channel k maps to c = 2k and right channel k maps to c = 2k+1. In the stereo modes, pin k supplies channel k.
- R10: When the last right-channel word of a frame completes, and a left word was started earlier in that frame, all six words are loaded into `pcm` together. `frame_valid` is high for exactly that one cycle, and `pcm` does not change at any other time.
- R11: Modes 110 and 111 capture nothing. In those modes `pcm` stays as it was and `frame_valid` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk | input | 1 | Bit clock, synchronous to clk |
| wclk | input | 1 | Word clock or frame sync, synchronous to clk |
| sdin | input | NPIN | Serial data pins; packed modes use pin 0 |
| mode | input | 3 | Framing select |
| wlen | input | 2 | Word-length select |
| pcm | output | 2*NPIN*WMAX | Six left-aligned channel words |
| frame_valid | output | 1 | One-cycle strobe when `pcm` is loaded |

## Verification
The hardest condition to reach is a frame that is complete and locked. A framing edge is needed before any capture. For I2S and the 256-clock packed mode, the first frame after reset has no such edge at its start, so it is discarded. Every case therefore sends an unchecked warm-up frame first, followed by a second frame whose samples are known. The bench then counts strobes over that second frame only. Bit positions beyond the word length, and the unused slots, carry random bits, so any leak of those bits into a sample shows up at `pcm`.

// File: rtl/serial_audio_rx.sv
module serial_audio_rx #(
  parameter int NPIN = 3,
  parameter int WMAX = 24
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bclk,
  input  logic                   wclk,
  input  logic [NPIN-1:0]        sdin,
  input  logic [2:0]             mode,
  input  logic [1:0]             wlen,
  output logic [2*NPIN*WMAX-1:0] pcm,
  output logic                   frame_valid
);
  localparam int NCH = 2 * NPIN;
  localparam logic [2:0] M_I2S = 3'd0, M_RJ = 3'd1, M_DSP = 3'd2, M_LJ = 3'd3;
  localparam logic [2:0] M_P256 = 3'd4, M_P128 = 3'd5;
  localparam logic [NCH*WMAX-1:0] LOW16 = {NCH{{16{1'b0}}, {(WMAX-16){1'b1}}}};
  localparam logic [NCH*WMAX-1:0] LOW20 = {NCH{{20{1'b0}}, {(WMAX-20){1'b1}}}};

  logic       bclk_q, wclk_q, synced, dsp_hf, dsp_nx, seen_l, pend;
  logic [4:0] cfg_q;
  logic [7:0] pcnt, pcur, wl, wlim, off, q, o, idx, grp;
  logic       ev, bnd, cap, rgt, last, go;
  logic [NCH-1:0]  hit;
  logic [WMAX-1:0] stg    [NCH];
  logic [WMAX-1:0] stg_nx [NCH];

  assign ev = (mode == M_DSP) ? (~bclk & bclk_q) : (bclk & ~bclk_q);
  assign wl = (wlen == 2'b01) ? 8'd20 : (wlen == 2'b10) ? 8'd16 : 8'(WMAX);
  assign wlim = (mode == M_P128 && wl > 8'd20) ? 8'd20 : wl;

  always_comb begin
    unique case (mode)
      M_I2S, M_RJ, M_LJ: bnd = wclk ^ wclk_q;
      M_DSP, M_P128:     bnd = wclk & ~wclk_q;
      M_P256:            bnd = ~wclk & wclk_q;
      default:           bnd = 1'b0;
    endcase
  end

  assign pcur = bnd ? 8'd0 : (pcnt == 8'hFF) ? pcnt : pcnt + 8'd1;

  always_comb begin
    cap = 1'b0; idx = '0; rgt = 1'b0; grp = '0; off = '0; q = '0; o = '0;
    unique case (mode)
      M_I2S, M_RJ, M_DSP, M_LJ: begin
        off = (mode == M_LJ) ? 8'd0 : (mode == M_RJ) ? 8'd32 - wlim : 8'd1;
        rgt = (mode == M_I2S) ? wclk : (mode == M_DSP) ? (bnd ? dsp_nx : dsp_hf) : ~wclk;
        if (pcur >= off && pcur - off < wlim) begin
          cap = 1'b1;
          idx = pcur - off;
        end
      end
      M_P256: begin
        q   = {5'd0, pcur[7:5]};
        o   = {3'd0, pcur[4:0]};
        rgt = q > 8'(NPIN);
        grp = rgt ? q - 8'(NPIN) - 8'd1 : q;
        cap = (grp < 8'(NPIN)) && (o != 8'd0) && (o - 8'd1 < wlim);
        idx = o - 8'd1;
      end
      M_P128: begin
        rgt = pcur >= 8'd64;
        q   = rgt ? pcur - 8'd64 : pcur;
        grp = q / 8'd20;
        o   = q - grp * 8'd20;
        cap = (grp < 8'(NPIN)) && (o < wlim);
        idx = o;
      end
      default: ;
    endcase
  end

  assign go   = ev && cap && (synced || bnd);
  assign last = rgt && (idx == wlim - 8'd1) && (!mode[2] || grp == 8'(NPIN - 1));

  always_comb begin
    for (int c = 0; c < NCH; c++) begin
      hit[c] = go && (mode[2] ? (c == 2 * int'(grp) + int'(rgt)) : ((c % 2) == int'(rgt)));
      stg_nx[c] = (idx == 8'd0) ? '0 : stg[c];
      if (idx < 8'(WMAX))
        stg_nx[c][WMAX-1-int'(idx)] = mode[2] ? sdin[0] : sdin[c/2];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_q <= 1'b0; wclk_q <= 1'b0; pcnt <= '0; synced <= 1'b0;
      dsp_hf <= 1'b0; dsp_nx <= 1'b0; seen_l <= 1'b0; pend <= 1'b0; cfg_q <= '0;
    end else begin
      bclk_q <= bclk;
      cfg_q  <= {mode, wlen};
      pend   <= 1'b0;
      if (ev) begin
        wclk_q <= wclk;
        pcnt   <= pcur;
        if (bnd) synced <= 1'b1;
        if (bnd && mode == M_DSP) begin
          dsp_hf <= dsp_nx;
          dsp_nx <= ~dsp_nx;
        end
        if (go && !rgt && idx == 8'd0) seen_l <= 1'b1;
        if (go && last && seen_l) begin
          pend   <= 1'b1;
          seen_l <= 1'b0;
        end
      end
      if (cfg_q != {mode, wlen}) begin
        synced <= 1'b0;
        seen_l <= 1'b0;
        dsp_nx <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++) stg[c] <= '0;
      pcm <= '0;
      frame_valid <= 1'b0;
    end else begin
      for (int c = 0; c < NCH; c++) begin
        if (hit[c]) stg[c] <= stg_nx[c];
        if (pend) pcm[c*WMAX +: WMAX] <= stg[c];
      end
      frame_valid <= pend;
    end
  end

  a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |=> !frame_valid);

  a_r10_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_valid |-> $stable(pcm));

  a_r11_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[2:1] == 2'b11 && $stable(mode)) |=> !frame_valid);

  a_r8_short_word: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_valid && wlen == 2'b10 && $past(wlen) == 2'b10 && $past(wlen, 2) == 2'b10)
      |-> ((pcm & LOW16) == '0));

  a_r7_packed_cap: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_valid && mode == M_P128 && $past(mode) == M_P128 && $past(mode, 2) == M_P128)
      |-> ((pcm & LOW20) == '0));
endmodule

// File: tb/serial_audio_rx_test.sv
module serial_audio_rx_test;
  logic         clk = 0, rst_n = 0, bclk = 0, wclk = 0;
  logic [2:0]   sdin = 0, mode = 0;
  logic [1:0]   wlen = 0;
  logic [143:0] pcm;
  logic         frame_valid;
  int checks = 0, errors = 0, vcnt = 0, wbits = 24;
  bit done = 0;
  logic [23:0] smp [6];

  always #10 clk = ~clk;

  serial_audio_rx uut (.clk(clk), .rst_n(rst_n), .bclk(bclk), .wclk(wclk), .sdin(sdin),
                       .mode(mode), .wlen(wlen), .pcm(pcm), .frame_valid(frame_valid));

  always @(posedge clk) if (rst_n && frame_valid) vcnt++;

  task automatic check(string tag, logic [143:0] act, logic [143:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic dbit(int ch, int i);
    if (i >= 0 && i < wbits) return smp[ch][23-i];
    return 1'($urandom);
  endfunction

  function automatic logic [143:0] expv();
    logic [143:0] e;
    for (int c = 0; c < 6; c++) e[c*24 +: 24] = smp[c] & (24'hFFFFFF << (24 - wbits));
    return e;
  endfunction

  function automatic string tag_of(int m);
    case (m)
      0: return "R2";
      1: return "R4";
      2: return "R5";
      3: return "R3";
      4: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic fill();
    for (int c = 0; c < 6; c++) smp[c] = 24'($urandom);
  endtask

  task automatic period(logic lv, logic [2:0] d);
    @(negedge clk); bclk = 0;
    @(negedge clk); wclk = lv; sdin = d;
    @(negedge clk); bclk = 1;
    @(negedge clk);
  endtask

  task automatic do_reset(int m, int wl);
    @(negedge clk);
    rst_n = 0; bclk = 0; wclk = 0; sdin = 0;
    mode = 3'(m); wlen = 2'(wl);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic send_frame(int shape);
    logic [2:0] d;
    logic lv;
    if (shape < 4) begin
      for (int h = 0; h < 2; h++)
        for (int n = 0; n < 36; n++) begin
          int off;
          off = (shape == 3) ? 0 : (shape == 1) ? 32 - wbits : 1;
          lv = (shape == 0) ? (h == 1) : (shape == 2) ? (n == 0) : (h == 0);
          for (int k = 0; k < 3; k++) d[k] = (n < 32) ? dbit(2*k + h, n - off) : 1'($urandom);
          period(lv, d);
        end
    end else if (shape == 4) begin
      for (int n = 0; n < 260; n++) begin
        int s, o, ch;
        s = n / 32; o = n % 32; ch = -1;
        if (n < 256) begin
          if (s < 3) ch = 2 * s;
          else if (s >= 4 && s < 7) ch = 2 * (s - 4) + 1;
        end
        lv = (n >= 128);
        d = {1'($urandom), 1'($urandom), (ch >= 0) ? dbit(ch, o - 1) : 1'($urandom)};
        period(lv, d);
      end
    end else begin
      for (int n = 0; n < 132; n++) begin
        int qq, ch;
        qq = (n >= 64) ? n - 64 : n; ch = -1;
        if (n < 128 && qq < 60) ch = 2 * (qq / 20) + ((n >= 64) ? 1 : 0);
        lv = (n < 64);
        d = {1'($urandom), 1'($urandom), (ch >= 0) ? dbit(ch, qq % 20) : 1'($urandom)};
        period(lv, d);
      end
    end
  endtask

  task automatic run(int m, int wl);
    int c0;
    string t;
    do_reset(m, wl);
    wbits = (wl == 1) ? 20 : (wl == 2) ? 16 : 24;
    if (m == 5 && wbits > 20) wbits = 20;
    t = $sformatf("%s R8 R9 mode=%0d wlen=%0d", tag_of(m), m, wl);
    fill(); send_frame(m);
    fill(); c0 = vcnt; send_frame(m);
    repeat (4) @(negedge clk);
    check({"R10 strobe count ", t}, 144'(vcnt - c0), 144'(1));
    check({"data ", t}, pcm, expv());
  endtask

  initial begin
    int c0;
    void'($urandom(32'd2024));
    do_reset(0, 0);
    check("R1 reset pcm", pcm, '0);
    check("R1 reset strobe", 144'(frame_valid), '0);
    for (int m = 0; m < 6; m++)
      for (int wl = 0; wl < 4; wl++) run(m, wl);
    for (int r = 0; r < 6; r++) run(int'($urandom % 6), int'($urandom % 4));
    for (int m = 6; m < 8; m++) begin
      do_reset(m, 0);
      wbits = 24;
      c0 = vcnt;
      fill(); send_frame(4); send_frame(3); send_frame(5);
      check($sformatf("R11 strobe count mode=%0d", m), 144'(vcnt - c0), '0);
      check($sformatf("R11 pcm untouched mode=%0d", m), pcm, '0);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    done = 1;
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R10 watchdog: actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule